// File: doc/BRIEF.md
# Lane Test-Pattern Engine: Pseudo-Random Generator and Self-Synchronising Checker

This block produces and checks test traffic for one serial lane, working on a parallel word of `DATA_W` bits (default 16) at one word per clock. The transmit side emits either a pseudo-random bit stream or a repeated programmable symbol. Six feedback polynomials are available for the random stream, and a polarity control can complement that stream. The fixed symbol can be complemented on every other word to keep the line DC balanced.

The receive side rebuilds the expected stream from the bits it has already received, so it needs no seed exchange with the far end. It declares lock once its history holds real data and a run of clean words has followed. From then on it adds every mismatched bit to an 11-bit error total that saturates and can be cleared.

Inside each word, the earliest bit in time sits in the most significant position. In loopback use, the receive input is wired to the transmit output of the same block, or to the partner block's output, with the same pattern select and polarity on both ends.

Top module: `prbs_engine`

## Requirements
- R1: The stream obeys b[k] = b[k-n] XOR b[k-t]. The select codes map as follows: 010 gives n=11, t=9; 011 gives n=15, t=14; 100 gives n=23, t=18; 101 gives n=31, t=28; 110 gives n=58, t=39; 111 gives n=63, t=62. Within each word, the oldest bit is in bit DATA_W-1.
- R2: Select codes 000 and 001 behave exactly like code 010 (n=11, t=9).
- R3: While reset is held, `txData`, `errCount` and `rxLocked` are zero. The generator starts as if the n bits before the first output bit were all ones, and its state register is never all zero.
- R4: With `polInvEn`=1, every random output bit is complemented, and the checker complements received bits before comparing them. Polarity has no effect in fixed mode.
- R5: With `fixedMode`=1 and `altInvEn`=0, every output word equals `fixedPat`, whatever the polarity setting.
- R6: With `fixedMode`=1 and `altInvEn`=1, the first word after reset (or after entering fixed mode) is `fixedPat`. After that, words alternate between the bitwise complement and the plain value.
- R7: The checker predicts each received bit from the bits it received n and t positions earlier. One flipped bit in a locked clean stream therefore adds exactly 3 to `errCount`.
- R8: `rxLocked` rises only after ceil(63/DATA_W) fill words followed by 4 consecutive error-free words. It then stays high until reset. Errors are not counted while it is low.
- R9: `errCount` is 11 bits wide, never decreases except on clear, and saturates at 2047 without wrapping.
- R10: A one-cycle pulse on `cntClr` makes `errCount` read zero in the next cycle. Clear takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| patSel | input | 3 | Polynomial select |
| fixedMode | input | 1 | 1: send fixed symbol, 0: send random stream |
| fixedPat | input | DATA_W | Programmable fixed symbol |
| altInvEn | input | 1 | Complement every second fixed symbol |
| polInvEn | input | 1 | Complement random data on transmit and receive |
| cntClr | input | 1 | Zero the error count |
| rxData | input | DATA_W | Received word |
| txData | output | DATA_W | Generated word |
| rxLocked | output | 1 | Checker synchronised |
| errCount | output | 11 | Saturating bit-error total |

## Verification
The assertions assume that `patSel` and `polInvEn` change only while reset is held. They also assume that `cntClr` is a level that software may hold for any number of cycles. The bench respects this by reprogramming the select and polarity only inside a reset window. Errors are injected only on the receive side, either by an XOR mask on the looped-back word or by replacing that word with random words, so the generator's own sequence is never disturbed while the checker is being measured.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int unsigned MAX_ORDER = 63;
  localparam int unsigned IDX_W     = 6;

  typedef struct packed {
    logic invSym;     // complement the current fixed symbol
    logic clrCnt;     // zero the error total
    logic countErrs;  // add this word's errors to the total
  } strobe_t;

  function automatic logic [IDX_W-1:0] polyOrder(input logic [2:0] sel);
    case (sel)
      3'b011:  return 6'd15;
      3'b100:  return 6'd23;
      3'b101:  return 6'd31;
      3'b110:  return 6'd58;
      3'b111:  return 6'd63;
      default: return 6'd11;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] polyTap(input logic [2:0] sel);
    case (sel)
      3'b011:  return 6'd14;
      3'b100:  return 6'd18;
      3'b101:  return 6'd28;
      3'b110:  return 6'd39;
      3'b111:  return 6'd62;
      default: return 6'd9;
    endcase
  endfunction

endpackage

// File: rtl/prbs_dp.sv
module prbs_dp
  import prbs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ERR_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        patSel,
  input  logic              fixedMode,
  input  logic [DATA_W-1:0] fixedPat,
  input  logic              polInvEn,
  input  logic [DATA_W-1:0] rxData,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] txData,
  output logic [ERR_W-1:0]  errCount,
  output logic              wordClean
);

  localparam int unsigned NUM_W = $clog2(DATA_W + 1);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic [MAX_ORDER-1:0] genState, genNext, chkHist, chkNext, actMask;
  logic [DATA_W-1:0]    prbsWord, txWord, errBits;
  logic [IDX_W-1:0]     ordN, tapT;
  logic [NUM_W-1:0]     errNum;
  logic [ERR_W:0]       sumW;
  logic [ERR_W-1:0]     satVal;

  assign ordN = polyOrder(patSel);
  assign tapT = polyTap(patSel);

  // bits of the state that the selected polynomial actually uses
  always_comb begin
    for (int j = 0; j < MAX_ORDER; j++) actMask[j] = (j < int'(ordN));
  end

  // generator: DATA_W shifts per clock, newest bit at index 0
  always_comb begin
    logic [MAX_ORDER-1:0] s;
    logic nb;
    s = genState;
    if ((genState & actMask) == '0) s = '1;
    prbsWord = '0;
    for (int i = 0; i < DATA_W; i++) begin
      nb = s[ordN - 6'd1] ^ s[tapT - 6'd1];
      s  = {s[MAX_ORDER-2:0], nb};
      prbsWord[DATA_W-1-i] = nb;
    end
    genNext = s;
  end

  assign txWord = fixedMode ? (fixedPat ^ {DATA_W{strb.invSym}})
                            : (prbsWord ^ {DATA_W{polInvEn}});

  // checker: predict each bit from received history, then shift it in
  always_comb begin
    logic [MAX_ORDER-1:0] h;
    logic rb, pb;
    h = chkHist;
    errBits = '0;
    for (int i = 0; i < DATA_W; i++) begin
      rb = rxData[DATA_W-1-i] ^ polInvEn;
      pb = h[ordN - 6'd1] ^ h[tapT - 6'd1];
      errBits[DATA_W-1-i] = rb ^ pb;
      h = {h[MAX_ORDER-2:0], rb};
    end
    chkNext = h;
  end

  always_comb begin
    errNum = '0;
    for (int i = 0; i < DATA_W; i++) errNum = errNum + NUM_W'(errBits[i]);
  end

  assign wordClean = (errBits == '0);
  assign sumW      = {1'b0, errCount} + (ERR_W+1)'(errNum);
  assign satVal    = (sumW > {1'b0, CNT_MAX}) ? CNT_MAX : sumW[ERR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      genState <= '1;
      txData   <= '0;
      chkHist  <= '0;
      errCount <= '0;
    end else begin
      genState <= genNext;
      txData   <= txWord;
      chkHist  <= chkNext;
      if (strb.clrCnt)         errCount <= '0;
      else if (strb.countErrs) errCount <= satVal;
    end
  end

  assert_state_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    genState != '0);
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == CNT_MAX && !strb.clrCnt) |=> errCount == CNT_MAX);
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrCnt |=> errCount >= $past(errCount));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> errCount == '0);
  assert_idle_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countErrs && !strb.clrCnt) |=> $stable(errCount));

endmodule

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LOCK_WORDS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    fixedMode,
  input  logic    altInvEn,
  input  logic    cntClr,
  input  logic    wordClean,
  output strobe_t strb,
  output logic    rxLocked
);

  localparam int unsigned FILL_WORDS = (MAX_ORDER + DATA_W - 1) / DATA_W;
  localparam int unsigned FILL_W     = $clog2(FILL_WORDS + 1);
  localparam int unsigned RUN_W      = $clog2(LOCK_WORDS + 1);

  logic              phase, locked;
  logic [FILL_W-1:0] fillCnt;
  logic [RUN_W-1:0]  runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= 1'b0;
      locked  <= 1'b0;
      fillCnt <= '0;
      runCnt  <= '0;
    end else begin
      phase <= fixedMode ? ~phase : 1'b0;
      if (fillCnt != FILL_W'(FILL_WORDS)) begin
        fillCnt <= fillCnt + 1'b1;
      end else if (!locked) begin
        if (wordClean) begin
          if (runCnt == RUN_W'(LOCK_WORDS - 1)) locked <= 1'b1;
          else                                   runCnt <= runCnt + 1'b1;
        end else begin
          runCnt <= '0;
        end
      end
    end
  end

  assign strb.invSym    = altInvEn & phase;
  assign strb.clrCnt    = cntClr;
  assign strb.countErrs = locked;
  assign rxLocked       = locked;

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);
  assert_no_lock_dirty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !wordClean) |=> !locked);

endmodule

// File: rtl/prbs_engine.sv
module prbs_engine
  import prbs_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned ERR_W      = 11,
  parameter int unsigned LOCK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        patSel,
  input  logic              fixedMode,
  input  logic [DATA_W-1:0] fixedPat,
  input  logic              altInvEn,
  input  logic              polInvEn,
  input  logic              cntClr,
  input  logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] txData,
  output logic              rxLocked,
  output logic [ERR_W-1:0]  errCount
);

  strobe_t strb;
  logic    wordClean;

  prbs_ctrl #(.DATA_W(DATA_W), .LOCK_WORDS(LOCK_WORDS)) uCtrl (
    .clk(clk), .rstN(rstN), .fixedMode(fixedMode), .altInvEn(altInvEn),
    .cntClr(cntClr), .wordClean(wordClean), .strb(strb), .rxLocked(rxLocked)
  );

  prbs_dp #(.DATA_W(DATA_W), .ERR_W(ERR_W)) uDp (
    .clk(clk), .rstN(rstN), .patSel(patSel), .fixedMode(fixedMode),
    .fixedPat(fixedPat), .polInvEn(polInvEn), .rxData(rxData), .strb(strb),
    .txData(txData), .errCount(errCount), .wordClean(wordClean)
  );

endmodule

// File: tb/sim_prbs_engine.sv
module sim_prbs_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  patSel = 3'b010;
  logic        fixedMode = 1'b0;
  logic [15:0] fixedPat = 16'h0000;
  logic        altInvEn = 1'b0;
  logic        polInvEn = 1'b0;
  logic        cntClr = 1'b0;
  logic        useRnd = 1'b0;
  logic [15:0] rndWord = 16'h0000;
  logic [15:0] errMask = 16'h0000;
  logic [15:0] rxData, txData;
  logic        rxLocked;
  logic [10:0] errCount;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit refBits [0:2047];
  int mdlN, mdlT;

  assign rxData = useRnd ? rndWord : (txData ^ errMask);

  always #4 clk = ~clk;

  prbs_engine u0 (
    .clk(clk), .rstN(rstN), .patSel(patSel), .fixedMode(fixedMode),
    .fixedPat(fixedPat), .altInvEn(altInvEn), .polInvEn(polInvEn),
    .cntClr(cntClr), .rxData(rxData), .txData(txData),
    .rxLocked(rxLocked), .errCount(errCount)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stepWord();
    @(posedge clk);
    @(negedge clk);
    if (useRnd) rndWord = 16'($urandom);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // reference stream from the recurrence, n prior bits all ones
  task automatic buildRef(input logic [2:0] sel);
    case (sel)
      3'b011:  begin mdlN = 15; mdlT = 14; end
      3'b100:  begin mdlN = 23; mdlT = 18; end
      3'b101:  begin mdlN = 31; mdlT = 28; end
      3'b110:  begin mdlN = 58; mdlT = 39; end
      3'b111:  begin mdlN = 63; mdlT = 62; end
      default: begin mdlN = 11; mdlT = 9;  end
    endcase
    for (int i = 0; i < 2048; i++)
      refBits[i] = (i < mdlN) ? 1'b1 : (refBits[i-mdlN] ^ refBits[i-mdlT]);
  endtask

  function automatic logic [15:0] modelWord(input int k);
    logic [15:0] w;
    for (int j = 0; j < 16; j++) w[15-j] = refBits[mdlN + 16*k + j];
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R3: reset values
    repeat (2) @(negedge clk);
    chk(txData == 16'h0, "R3 txData in reset", 32'(txData), 0);
    chk(errCount == 11'h0, "R3 errCount in reset", 32'(errCount), 0);
    chk(rxLocked == 1'b0, "R3 rxLocked in reset", 32'(rxLocked), 0);

    // R1, R2, R4: every select code, both polarities
    for (int sel = 0; sel < 8; sel++) begin
      for (int pol = 0; pol < 2; pol++) begin
        int mism = 0;
        logic [15:0] badA = 0, badE = 0;
        rstN = 1'b0;
        patSel = 3'(sel);
        polInvEn = pol[0];
        buildRef(3'(sel));
        doReset();
        for (int k = 0; k < 40; k++) begin
          logic [15:0] e;
          stepWord();
          e = modelWord(k) ^ {16{pol[0]}};
          if (txData !== e) begin
            if (mism == 0) begin badA = txData; badE = e; end
            mism++;
          end
        end
        chk(mism == 0, (sel < 2) ? "R2 reserved code" : (pol != 0 ? "R4 inverted stream" : "R1 stream"),
            32'(badA), 32'(badE));
      end
    end

    // R5: fixed symbol, polarity ignored
    fixedMode = 1'b1; fixedPat = 16'hC35A; altInvEn = 1'b0; polInvEn = 1'b1;
    doReset();
    begin
      int mism = 0;
      for (int k = 0; k < 12; k++) begin
        stepWord();
        if (txData !== 16'hC35A) mism++;
      end
      chk(mism == 0, "R5 fixed symbol", 32'(txData), 32'hC35A);
    end

    // R6: alternate complement, first word plain
    altInvEn = 1'b1; polInvEn = 1'b0;
    doReset();
    begin
      int mism = 0;
      logic [15:0] e = 0;
      for (int k = 0; k < 12; k++) begin
        stepWord();
        e = (k % 2 == 1) ? ~16'hC35A : 16'hC35A;
        if (txData !== e) mism++;
      end
      chk(mism == 0, "R6 alternating symbol", 32'(txData), 32'(e));
    end
    fixedMode = 1'b0; altInvEn = 1'b0;

    // R8: random input never locks, nothing counted
    rstN = 1'b0; patSel = 3'b010; useRnd = 1'b1;
    doReset();
    repeat (60) stepWord();
    chk(rxLocked == 1'b0, "R8 no lock on random data", 32'(rxLocked), 0);
    chk(errCount == 11'h0, "R8 no count while unlocked", 32'(errCount), 0);

    // R8, R7: clean loopback locks, single flipped bit counts 3 (n=11)
    useRnd = 1'b0;
    doReset();
    repeat (30) stepWord();
    chk(rxLocked == 1'b1, "R8 lock on clean loopback", 32'(rxLocked), 1);
    chk(errCount == 11'h0, "R8 no errors on clean loopback", 32'(errCount), 0);
    errMask = 16'h0100;
    stepWord();
    errMask = 16'h0000;
    repeat (4) stepWord();
    chk(errCount == 11'd3, "R7 single bit error order 11", 32'(errCount), 3);

    // R7, R4: order 63 with inverted polarity
    rstN = 1'b0; patSel = 3'b111; polInvEn = 1'b1;
    doReset();
    repeat (30) stepWord();
    chk(rxLocked == 1'b1, "R4 lock with polarity inverted", 32'(rxLocked), 1);
    chk(errCount == 11'h0, "R4 clean count with polarity inverted", 32'(errCount), 0);
    errMask = 16'h0004;
    stepWord();
    errMask = 16'h0000;
    repeat (8) stepWord();
    chk(errCount == 11'd3, "R7 single bit error order 63", 32'(errCount), 3);

    // R10: clear wins over counting during random data
    useRnd = 1'b1;
    repeat (5) stepWord();
    cntClr = 1'b1;
    stepWord();
    cntClr = 1'b0;
    chk(errCount == 11'h0, "R10 clear while counting", 32'(errCount), 0);
    chk(rxLocked == 1'b1, "R8 lock held under errors", 32'(rxLocked), 1);

    // R9: saturation
    repeat (700) stepWord();
    chk(errCount == 11'd2047, "R9 saturated", 32'(errCount), 2047);
    repeat (20) stepWord();
    chk(errCount == 11'd2047, "R9 stays saturated", 32'(errCount), 2047);

    // R10: clear after returning to clean loopback
    useRnd = 1'b0;
    repeat (8) stepWord();
    cntClr = 1'b1;
    stepWord();
    cntClr = 1'b0;
    chk(errCount == 11'h0, "R10 clear next cycle", 32'(errCount), 0);
    repeat (10) stepWord();
    chk(errCount == 11'h0, "R10 stays clear on clean data", 32'(errCount), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule